// File: doc/BRIEF.md
# Overflow-Tick Alarm Sequencer

This block extends a hardware timer with an 8-bit tick counter that advances by one on each single-cycle overflow pulse from the timer. A polled alarm sits on top of that counter. The alarm stores a target count, which is the count when the alarm was set plus a requested delay, wrapped to 8 bits. The alarm fires when the live count equals that target exactly. An ordered comparison is not used, because it fails once the counter wraps past 8'hFF.

A small sequencer drives the alarm through three stages. After a start pulse it shows stage A. When the first delay expires it moves to stage B, and when the second delay expires it moves to stage C, where it stays. The second target is built from the first target and not from the live count, so timing error cannot build up from one stage to the next. Each stage entry raises a one-clock strobe, which a downstream display driver can use to latch the new stage code.

Top module: `tick_alarm_seq`

## Requirements
- R1: `tick_count` is 8'h00 after reset. It rises by exactly one on the clock edge that samples `ovf_tick` high and keeps its value on every other edge. It wraps from 8'hFF to 8'h00.
- R2: After reset `stage_code` is 2'd0 (idle) and `stage_strobe` is low. Overflow pulses alone never move the stage out of idle.
- R3: The clock edge that samples `start` high sets `stage_code` to 2'd1 (stage A). It also sets the alarm target to `tick_count + delay_a` modulo 256, using the count before that edge.
- R4: The alarm fires only when `tick_count` equals the target. The stage advances on the clock edge after the count reaches the target, even when the target has wrapped below the count at which the alarm was set.
- R5: Stage A changes to `stage_code` 2'd2 (stage B) after exactly `delay_a` overflow pulses. Stage B changes to 2'd3 (stage C) after exactly `delay_b` further pulses. The B target is the A target plus `delay_b`.
- R6: A delay value of 0 means 256 overflow pulses, which is one full lap of the counter.
- R7: Once in stage C, `stage_code` stays 2'd3 for any number of overflow pulses, until the next start or reset.
- R8: `stage_strobe` is high for exactly one clock after each entry into stage A, B or C, and is low at all other times.
- R9: A start pulse in any stage returns the sequencer to stage A and sets a fresh target from the live count, so stage B then follows `delay_a` pulses after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovf_tick | input | 1 | One-cycle pulse, one per timer overflow |
| start | input | 1 | One-cycle pulse that begins or restarts the sequence |
| delay_a | input | 8 | Pulses from stage A to stage B (0 means 256) |
| delay_b | input | 8 | Pulses from stage B to stage C (0 means 256) |
| stage_code | output | 2 | 0 idle, 1 stage A, 2 stage B, 3 stage C |
| stage_strobe | output | 1 | One-clock pulse on entry into each stage |
| tick_count | output | 8 | Current overflow tick count |

## Verification
`tick_count` is due one clock after the edge that samples an overflow pulse. The stage and strobe are due one clock after that, because the match is a combinational compare of the registered count and the registered target, and the stage register acts on it at the next edge. Stage A and its strobe are due at the edge that samples `start`. The bench drives every input on the falling edge. It raises each overflow pulse for one cycle and samples two falling edges after raising it, so the count, the stage and the strobe are all settled and the strobe is still high when read. Stage changes are counted in whole overflow pulses, and each count is compared with the delay the bench computes, where 0 stands for 256.

// File: rtl/tick_alarm_pkg.sv
package tick_alarm_pkg;

    localparam int TICK_W = 8;

    typedef logic [TICK_W-1:0] tick_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_A    = 2'd1,
        ST_B    = 2'd2,
        ST_C    = 2'd3
    } stage_e;

    // Alarm state: armed flag, "count has moved since arming" flag, target
    typedef struct packed {
        logic  valid;
        logic  moved;
        tick_t target;
    } alarm_s;

    // Modulo addition; width truncation gives the wrap
    function automatic tick_t target_of(tick_t base, tick_t delay);
        return base + delay;
    endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter
    import tick_alarm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ovf_tick,
    output tick_t count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (ovf_tick)
            count <= count + tick_t'(1);
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        ovf_tick |=> count == tick_t'($past(count) + tick_t'(1))); // R1

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ovf_tick |=> $stable(count)); // R1

endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import tick_alarm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  arm,
    input  logic  disarm,
    input  tick_t base,
    input  tick_t delay,
    input  tick_t count,
    input  logic  ovf_tick,
    output logic  fire,
    output tick_t target
);

    alarm_s st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (arm) begin
            // moved starts set if the count steps on this same edge
            st.valid  <= 1'b1;
            st.moved  <= ovf_tick;
            st.target <= target_of(base, delay);
        end else if (disarm) begin
            st.valid <= 1'b0;
        end else if (ovf_tick) begin
            st.moved <= 1'b1;
        end
    end

    // Equality only; moved stops a zero delay from firing at once
    assign fire   = st.valid && st.moved && (count == st.target);
    assign target = st.target;

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import tick_alarm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   fire,
    input  tick_t  count,
    input  tick_t  target,
    input  tick_t  delay_a,
    input  tick_t  delay_b,
    output logic   arm,
    output logic   disarm,
    output tick_t  base,
    output tick_t  delay,
    output stage_e stage,
    output logic   strobe
);

    stage_e nxt;

    always_comb begin
        arm    = 1'b0;
        disarm = 1'b0;
        base   = count;
        delay  = delay_a;
        nxt    = stage;
        if (start) begin
            arm = 1'b1;
            nxt = ST_A;
        end else if (fire) begin
            unique case (stage)
                ST_A: begin
                    arm   = 1'b1;
                    base  = target;
                    delay = delay_b;
                    nxt   = ST_B;
                end
                ST_B: begin
                    disarm = 1'b1;
                    nxt    = ST_C;
                end
                default: nxt = stage;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage  <= ST_IDLE;
            strobe <= 1'b0;
        end else begin
            stage  <= nxt;
            strobe <= start || (nxt != stage);
        end
    end

    AST_STAGE_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (stage != $past(stage)) && !$past(start)
            |-> logic'(2'(stage) == 2'($past(stage)) + 2'd1)); // R5

    AST_C_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_C) && !start |=> stage == ST_C); // R7

    AST_STROBE_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (stage != $past(stage)) |-> strobe); // R8

    AST_IDLE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_IDLE) && !start |=> stage == ST_IDLE); // R2

endmodule

// File: rtl/tick_alarm_seq.sv
module tick_alarm_seq
    import tick_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ovf_tick,
    input  logic        start,
    input  logic [7:0]  delay_a,
    input  logic [7:0]  delay_b,
    output logic [1:0]  stage_code,
    output logic        stage_strobe,
    output logic [7:0]  tick_count
);

    tick_t  count;
    tick_t  target;
    tick_t  arm_base;
    tick_t  arm_delay;
    logic   fire;
    logic   arm;
    logic   disarm;
    stage_e stage;

    tick_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ovf_tick (ovf_tick),
        .count    (count)
    );

    alarm_unit u_alarm (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .disarm   (disarm),
        .base     (arm_base),
        .delay    (arm_delay),
        .count    (count),
        .ovf_tick (ovf_tick),
        .fire     (fire),
        .target   (target)
    );

    seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .fire    (fire),
        .count   (count),
        .target  (target),
        .delay_a (delay_a),
        .delay_b (delay_b),
        .arm     (arm),
        .disarm  (disarm),
        .base    (arm_base),
        .delay   (arm_delay),
        .stage   (stage),
        .strobe  (stage_strobe)
    );

    assign stage_code = stage;
    assign tick_count = count;

    AST_START_TO_A: assert property (@(posedge clk) disable iff (rst)
        start |=> stage_code == 2'd1 && stage_strobe); // R3

endmodule

// File: tb/tick_alarm_seq_bench.sv
module tick_alarm_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ovf_tick = 1'b0;
    logic       start = 1'b0;
    logic [7:0] delay_a = 8'd23;
    logic [7:0] delay_b = 8'd46;
    logic [1:0] stage_code;
    logic       stage_strobe;
    logic [7:0] tick_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_alarm_seq u_tick_alarm_seq (
        .clk          (clk),
        .rst          (rst),
        .ovf_tick     (ovf_tick),
        .start        (start),
        .delay_a      (delay_a),
        .delay_b      (delay_b),
        .stage_code   (stage_code),
        .stage_strobe (stage_strobe),
        .tick_count   (tick_count)
    );

    // {pre-advance ticks, delay_a, delay_b}
    localparam logic [23:0] VEC [5] = '{
        {8'd0,   8'd23, 8'd46},
        {8'd250, 8'd10, 8'd20},
        {8'd5,   8'd0,  8'd3},
        {8'd100, 8'd1,  8'd0},
        {8'd200, 8'd115, 8'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input logic [7:0] d);
        return (d == 8'd0) ? 256 : int'(d);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; start = 1'b0; ovf_tick = 1'b0;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
    endtask

    // raise one overflow pulse, sample two falling edges later
    task automatic do_tick();
        ovf_tick = 1'b1;
        @(negedge clk); ovf_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // ticks until stage leaves 'from'; returns pulses taken
    task automatic run_until_change(input logic [1:0] from, output int n, output bit strobe_ok);
        n = 0;
        strobe_ok = 1'b1;
        while (stage_code == from && n < 600) begin
            do_tick();
            n++;
            if (stage_code == from && stage_strobe) strobe_ok = 1'b0;
        end
        if (!stage_strobe) strobe_ok = 1'b0;
    endtask

    initial begin
        int n;
        bit sok;

        // reset state
        do_reset();
        check("R1 reset count", tick_count, 0);
        check("R2 reset stage", stage_code, 0);
        check("R2 reset strobe", stage_strobe, 0);

        // counter step, wrap, idle held by ticks alone
        do_tick();
        check("R1 step", tick_count, 1);
        for (int i = 0; i < 254; i++) do_tick();
        check("R1 at FF", tick_count, 255);
        check("R2 idle after ticks", stage_code, 0);
        do_tick();
        check("R1 wrap to 00", tick_count, 0);
        check("R2 no strobe in idle", stage_strobe, 0);

        // table of vectors
        for (int v = 0; v < 5; v++) begin
            logic [7:0] pre;
            {pre, delay_a, delay_b} = VEC[v];
            do_reset();
            for (int i = 0; i < int'(pre); i++) do_tick();
            check("R1 pre-advance", tick_count, int'(pre));
            do_start();
            check("R3 stage A", stage_code, 1);
            check("R8 strobe on A", stage_strobe, 1);
            @(negedge clk);
            check("R8 strobe one clock", stage_strobe, 0);
            run_until_change(2'd1, n, sok);
            check("R5 R4 R6 ticks A to B", n, eff(delay_a));
            check("R5 stage B", stage_code, 2);
            check("R8 strobe on B", int'(sok), 1);
            run_until_change(2'd2, n, sok);
            check("R5 R6 ticks B to C", n, eff(delay_b));
            check("R5 stage C", stage_code, 3);
            check("R8 strobe on C", int'(sok), 1);
        end

        // restart while running
        delay_a = 8'd20; delay_b = 8'd5;
        do_reset();
        do_start();
        for (int i = 0; i < 10; i++) do_tick();
        check("R9 still A", stage_code, 1);
        do_start();
        check("R9 restart A", stage_code, 1);
        check("R9 restart strobe", stage_strobe, 1);
        run_until_change(2'd1, n, sok);
        check("R9 ticks from restart", n, 20);
        run_until_change(2'd2, n, sok);
        check("R9 reach C", stage_code, 3);

        // C holds across laps
        sok = 1'b1;
        for (int i = 0; i < 300; i++) begin
            do_tick();
            if (stage_code != 2'd3 || stage_strobe) sok = 1'b0;
        end
        check("R7 C holds, no strobe", int'(sok), 1);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule